// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Path

This block adds two unsigned operands and a carry-in and gives back the sum and a carry-out. The operand word is cut into groups whose widths grow from the least significant end. The default 16-bit word uses groups of 2, 2, 3, 4 and 5 bits. Every group computes its local sum once, assuming no incoming carry, with a Brent-Kung style parallel-prefix tree of generate/propagate combine cells. The lowest group takes the external carry-in straight into its tree. Each higher group makes its "carry-in is one" result by incrementing its carry-zero result and group carry-out, one bit wider than the group, with an add-one converter. A 2-to-1 multiplexer then picks one of the two results, steered by the carry leaving the group below. Because the groups widen upward, the slower wide trees have more time to settle while the select carry ripples through the narrow groups beneath them.

The combinational result is captured in an output register with a synchronous, active-high reset, so the answer shows up one clock after the operands are presented. The width is a parameter. Group widths follow the rule "2, then 2, 3, 4, ..." and the last group is cut short so the widths add up to the word width.

Top module: `csa_sqrt_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` and `cout_q` are driven to zero at that edge.
- R2: With `rst` low, the concatenation {`cout_q`,`sum_q`} equals `a_in + b_in + cin`, taken as an unsigned (DATA_W+1)-bit value, one clock after the operands are sampled.
- R3: With DATA_W = 16 the groups span bits [1:0], [3:2], [6:4], [10:7] and [15:11]. A carry made just below any group boundary k (a = 2^k - 1, b = 1, cin = 0) gives a sum of exactly 2^k.
- R4: When `cin` = 0 and `b_in` = 0, `sum_q` equals `a_in` and `cout_q` is 0.
- R5: When `a_in` is all ones and `cin` = 1, the carry passes through every group, so `sum_q` equals `b_in` and `cout_q` is 1.
- R6: `cout_q` is 1 exactly when the true sum is 2^DATA_W or more. Example: 0x8000 + 0x8000 gives sum 0 with carry-out 1, and 0xFFFF + 0 with cin = 0 gives carry-out 0.
- R7: When both operands are zero, `sum_q` equals `cin` in bit 0 and zero elsewhere, and `cout_q` is 0.
- R8: For a different DATA_W, the same grouping rule holds with the top group truncated. With DATA_W = 7 (groups 2, 2, 3) the result is correct for every operand and carry-in combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | DATA_W | First operand |
| b_in | input | DATA_W | Second operand |
| cin | input | 1 | Carry-in to the least significant group |
| sum_q | output | DATA_W | Registered sum |
| cout_q | output | 1 | Registered carry-out of the top group |

## Verification
The bench builds two copies of the adder. The first uses DATA_W = 7, split into groups of 2, 2 and 3 bits. At that width all 2^15 combinations of operands and carry-in can be swept, so every pattern of select carries between groups is exercised, including every increment-path ripple. The second copy uses the default DATA_W = 16 with five groups. It receives directed boundary-crossing carries, all-ones and alternating operands, overflow cases and random vectors, all compared against arithmetic sums computed in the bench.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix combine: hi covers the more significant span, lo the less significant.
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Nominal width of group k: 2, 2, 3, 4, 5, ...
  function automatic int grp_nominal(int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  function automatic int grp_lsb(int k);
    int acc;
    acc = 0;
    for (int j = 0; j < 64; j++)
      if (j < k) acc += grp_nominal(j);
    return acc;
  endfunction

  function automatic int grp_count(int w);
    int acc;
    int cnt;
    acc = 0;
    cnt = 0;
    for (int j = 0; j < 64; j++)
      if (acc < w) begin
        acc += grp_nominal(j);
        cnt++;
      end
    return cnt;
  endfunction

  function automatic int grp_width(int w, int k);
    int lo;
    lo = grp_lsb(k);
    if (lo + grp_nominal(k) <= w) return grp_nominal(k);
    return w - lo;
  endfunction

endpackage

// File: rtl/csa_prefix_adder.sv
module csa_prefix_adder
  import csa_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int LV = (W > 1) ? $clog2(W) : 1;

  gp_t        leaf [W];
  gp_t        node [W];
  logic [W:0] carry;

  for (genvar i = 0; i < W; i++) begin : g_leaf
    assign leaf[i].g = a_i[i] & b_i[i];
    assign leaf[i].p = a_i[i] ^ b_i[i];
  end

  // Up-sweep then down-sweep; afterwards node[i] spans bits [i:0].
  always_comb begin
    for (int i = 0; i < W; i++) node[i] = leaf[i];
    for (int l = 0; l < LV; l++)
      for (int i = 0; i < W; i++)
        if (((i + 1) % (2 << l)) == 0)
          node[i] = gp_merge(node[i], node[i - (1 << l)]);
    for (int l = LV - 1; l >= 0; l--)
      for (int i = 0; i < W; i++)
        if ((((i + 1) % (2 << l)) == 0) && ((i + (1 << l)) < W))
          node[i + (1 << l)] = gp_merge(node[i + (1 << l)], node[i]);
  end

  assign carry[0] = cin_i;
  for (genvar i = 1; i <= W; i++) begin : g_carry
    assign carry[i] = node[i-1].g | (node[i-1].p & cin_i);
  end

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum_o[i] = leaf[i].p ^ carry[i];
  end

  assign cout_o = carry[W];

endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
  parameter int W = 4
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] inc_o
);

  logic [W:0] all_low;

  assign all_low[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign inc_o[i]     = val_i[i] ^ all_low[i];
    assign all_low[i+1] = all_low[i] & val_i[i];
  end

endmodule

// File: rtl/csa_mux2.sv
module csa_mux2 #(
  parameter int W = 4
) (
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  input  logic         sel_i,
  output logic [W-1:0] q_o
);

  assign q_o = sel_i ? d1_i : d0_i;

endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int W       = 4,
  parameter bit HAS_SEL = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  if (HAS_SEL) begin : g_select
    logic [W-1:0] s0;
    logic         c0;
    logic [W:0]   res0;
    logic [W:0]   res1;
    logic [W:0]   pick;

    csa_prefix_adder #(.W(W)) u_pfx (
      .a_i   (a_i),
      .b_i   (b_i),
      .cin_i (1'b0),
      .sum_o (s0),
      .cout_o(c0)
    );

    assign res0 = {c0, s0};

    csa_excess1 #(.W(W + 1)) u_inc (
      .val_i(res0),
      .inc_o(res1)
    );

    csa_mux2 #(.W(W + 1)) u_mux (
      .d0_i (res0),
      .d1_i (res1),
      .sel_i(cin_i),
      .q_o  (pick)
    );

    assign sum_o  = pick[W-1:0];
    assign cout_o = pick[W];
  end else begin : g_direct
    csa_prefix_adder #(.W(W)) u_pfx (
      .a_i   (a_i),
      .b_i   (b_i),
      .cin_i (cin_i),
      .sum_o (sum_o),
      .cout_o(cout_o)
    );
  end

endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder
  import csa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cin,
  output logic [DATA_W-1:0] sum_q,
  output logic              cout_q
);

  localparam int NGRP = grp_count(DATA_W);

  logic [NGRP:0]     chain;
  logic [DATA_W-1:0] sum_c;

  assign chain[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LSB = grp_lsb(g);
    localparam int GW  = grp_width(DATA_W, g);

    csa_group #(
      .W      (GW),
      .HAS_SEL(g > 0)
    ) u_grp (
      .a_i   (a_in[LSB +: GW]),
      .b_i   (b_in[LSB +: GW]),
      .cin_i (chain[g]),
      .sum_o (sum_c[LSB +: GW]),
      .cout_o(chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      cout_q <= chain[NGRP];
    end
  end

endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic              cin,
  input logic [DATA_W-1:0] sum_q,
  input logic              cout_q
);

  logic [DATA_W:0] ref_total;
  assign ref_total = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_q == '0) && !cout_q);

  assert_sum_matches_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {cout_q, sum_q} == $past(ref_total));

  assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
    (!cin && (b_in == '0)) |=> (sum_q == $past(a_in)) && !cout_q);

  assert_full_ripple_R5: assert property (@(posedge clk) disable iff (rst)
    ((&a_in) && cin) |=> cout_q && (sum_q == $past(b_in)));

  assert_zero_operands_R7: assert property (@(posedge clk) disable iff (rst)
    ((a_in == '0) && (b_in == '0)) |=> !cout_q && (sum_q == {{(DATA_W-1){1'b0}}, $past(cin)}));

endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_csa_sqrt_adder.sv
`timescale 1ns/1ps
module tb_csa_sqrt_adder;

  localparam int WB = 16;
  localparam int WS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [WB-1:0] a16 = '1, b16 = '1, s16;
  logic          c16 = 1'b1, co16;
  logic [WS-1:0] a7 = '1, b7 = '1, s7;
  logic          c7 = 1'b1, co7;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  csa_sqrt_adder #(.DATA_W(WB)) dut (
    .clk(clk), .rst(rst), .a_in(a16), .b_in(b16), .cin(c16),
    .sum_q(s16), .cout_q(co16)
  );

  csa_sqrt_adder #(.DATA_W(WS)) dut_small (
    .clk(clk), .rst(rst), .a_in(a7), .b_in(b7), .cin(c7),
    .sum_q(s7), .cout_q(co7)
  );

  task automatic check(input string tag, input logic [WB:0] got, input logic [WB:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run16(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic c, input string tag);
    logic [WB:0] exp;
    @(negedge clk);
    a16 = a; b16 = b; c16 = c;
    @(posedge clk);
    #1;
    exp = {1'b0, a} + {1'b0, b} + {{WB{1'b0}}, c};
    check(tag, {co16, s16}, exp);
  endtask

  task automatic run7(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic c);
    logic [WS:0] exp;
    @(negedge clk);
    a7 = a; b7 = b; c7 = c;
    @(posedge clk);
    #1;
    exp = {1'b0, a} + {1'b0, b} + {{WS{1'b0}}, c};
    check("R8 small width", {{(WB-WS){1'b0}}, co7, s7}, {{(WB-WS){1'b0}}, exp});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset wide", {co16, s16}, '0);
    check("R1 reset small", {{(WB-WS){1'b0}}, co7, s7}, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int ci = 0; ci < 2; ci++) begin
      run16(16'h0000, 16'h0000, ci[0], "R7 zero operands");
      run16(16'hFFFF, 16'h0000, ci[0], "R5 all ones");
      run16(16'hFFFF, 16'hFFFF, ci[0], "R5 all ones both");
      run16(16'hAAAA, 16'h5555, ci[0], "R2 alternating");
      run16(16'h5555, 16'h5555, ci[0], "R2 alternating same");
      run16(16'hAAAA, 16'hAAAA, ci[0], "R2 alternating high");
    end
    run16(16'h1234, 16'h0000, 1'b0, "R4 pass through");
    run16(16'hFEDC, 16'h0000, 1'b0, "R4 pass through");
    run16(16'hFFFF, 16'h3C5A, 1'b1, "R5 ripple with b");
    run16(16'h8000, 16'h8000, 1'b0, "R6 top overflow");
    run16(16'hFFFF, 16'h0001, 1'b0, "R6 wrap");
    run16(16'h7FFF, 16'h8000, 1'b0, "R6 no overflow");
    run16(16'hF800, 16'h0800, 1'b0, "R6 top group only");

    // R3: a carry formed just below each group boundary must land at the boundary bit
    for (int k = 1; k < WB; k++) begin
      run16(16'((32'd1 << k) - 1), 16'h0001, 1'b0, "R3 boundary carry");
      run16(16'((32'd1 << k) - 1), 16'h0000, 1'b1, "R3 boundary carry-in");
    end

    for (int i = 0; i < 3000; i++)
      run16(16'($urandom), 16'($urandom), 1'($urandom), "R2 random");

    // R8: exhaustive sweep at width 7
    for (int a = 0; a < 128; a++)
      for (int b = 0; b < 128; b++)
        for (int c = 0; c < 2; c++)
          run7(7'(a), 7'(b), c[0]);

    finish_run();
  end

endmodule